// File: doc/BRIEF.md
# Lookup-Ratio Clock Enable Divider with Gate

This block turns one parent clock into four divided outputs. Each output channel takes a 4-bit selector code and looks it up in a fixed, irregular table of division ratios. The code is not used as the divisor. Three channels take their selectors from one shared 12-bit control word. A fourth channel has its own control word, which holds both a selector and a stop bit.

Each channel produces two outputs and one flag:
- a one-cycle clock-enable pulse, once per divided period;
- a divided clock level, which has a 50% duty cycle when the ratio is even;
- a sticky flag that records any reserved selector code.

A new ratio takes effect only at the end of the running period. The stop bit is also acted on only at the end of a period. Downstream logic therefore never sees a shortened period.

Top module: `tbl_clkdiv_top`

## Requirements
- R1: Channel 0 reads `share_ctl[11:8]` and uses the ladder table. Codes 0 to 8 give 2, 3, 4, 6, 8, 12, 16, 18 and 24. Code 10 gives 36 and code 11 gives 48. Codes 9 and 12 to 15 are reserved.
- R2: Channel 1 reads `share_ctl[7:4]` and channel 2 reads `share_ctl[3:0]`. Both use the sparse table: code 12 gives 10, codes 4 to 8 give 8, 12, 16, 18 and 24, code 10 gives 36 and code 11 gives 48. Every other code is reserved.
- R3: Channel 3 reads `gate_ctl[3:0]`. Its table is the ladder table without code 0, so codes 1 to 8 give 3 to 24, code 10 gives 36 and code 11 gives 48. Every other code is reserved. Bits 7:4 of `gate_ctl` have no effect.
- R4: While a channel runs at ratio N, its `pulse_o` bit is high for exactly one cycle in every N parent cycles.
- R5: A change to a valid selector code takes effect only at the end of the current period. No period is ever shorter than the ratio that was in force when the period began.
- R6: A reserved code leaves the current ratio in force. It also sets that channel's `err_o` bit, which stays set until reset.
- R7: While `gate_ctl[8]` is 1, channel 3 stops at the end of its current period. After that, its pulse and divided clock stay low.
- R8: When `gate_ctl[8]` returns to 0, channel 3 restarts from count zero, using the latest valid code.
- R9: `divclk_o` is high for the first floor(N/2) cycles of each N-cycle period and low for the rest.
- R10: Reset is asynchronous and active low. It clears every pulse, divided clock and error bit. It loads start ratios of 2, 8, 8 and 3 for channels 0 to 3, and each channel starts running from count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| share_ctl | input | 12 | Selector codes for channels 0 to 2 |
| gate_ctl | input | 9 | Bit 8 stops channel 3 when set; bits 3:0 are its selector |
| pulse_o | output | 4 | Clock-enable pulse, one bit per channel |
| divclk_o | output | 4 | Divided clock level, one bit per channel |
| err_o | output | 4 | Sticky reserved-code flag, one bit per channel |

## Verification
Every output is registered. A selector or stop-bit change applied before a clock edge therefore appears at the earliest on the outputs after the period-end edge that follows it, and the error flag rises one edge after a reserved code is first sampled. The reference model in the bench advances on the same rising edge as the design and uses the same sampled inputs. All three outputs of every channel are compared on the following falling edge, so each comparison falls exactly in the cycle when the result is due. Inputs change only on falling edges, half a period away from any sampling edge.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int SEL_W   = 4;
  localparam int RATIO_W = 6;

  typedef enum logic [1:0] {TBL_LADDER, TBL_SPARSE, TBL_NOZERO} tbl_e;
  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [SEL_W-1:0]   sel_t;

  // Rising ladder of ratios shared by all three tables.
  function automatic ratio_t ladder(input int unsigned idx);
    case (idx)
      0:       return ratio_t'(2);
      1:       return ratio_t'(3);
      2:       return ratio_t'(4);
      3:       return ratio_t'(6);
      4:       return ratio_t'(8);
      5:       return ratio_t'(12);
      6:       return ratio_t'(16);
      7:       return ratio_t'(18);
      8:       return ratio_t'(24);
      9:       return ratio_t'(36);
      10:      return ratio_t'(48);
      default: return ratio_t'(0);
    endcase
  endfunction

  // Returns the ratio for a code; zero marks a reserved code.
  function automatic ratio_t ratio_of(input tbl_e t, input sel_t code);
    int unsigned idx;
    logic        on_ladder;
    on_ladder = 1'b1;
    if (code <= sel_t'(8))       idx = 32'(code);
    else if (code == sel_t'(10)) idx = 9;
    else if (code == sel_t'(11)) idx = 10;
    else begin
      idx       = 0;
      on_ladder = 1'b0;
    end
    case (t)
      TBL_LADDER: return on_ladder ? ladder(idx) : ratio_t'(0);
      TBL_SPARSE: begin
        if (code == sel_t'(12)) return ratio_t'(10);
        return (on_ladder && code >= sel_t'(4)) ? ladder(idx) : ratio_t'(0);
      end
      default: return (on_ladder && code != sel_t'(0)) ? ladder(idx) : ratio_t'(0);
    endcase
  endfunction

  function automatic ratio_t boot_ratio(input tbl_e t);
    case (t)
      TBL_LADDER: return ratio_t'(2);
      TBL_SPARSE: return ratio_t'(8);
      default:    return ratio_t'(3);
    endcase
  endfunction
endpackage

// File: rtl/tcd_decode.sv
module tcd_decode
  import tcd_pkg::*;
#(
  parameter tbl_e TBL = TBL_LADDER
) (
  input  logic [SEL_W-1:0]   sel_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               valid_o
);
  assign ratio_o = ratio_of(TBL, sel_i);
  assign valid_o = (ratio_o != '0);
endmodule

// File: rtl/tcd_channel.sv
module tcd_channel
  import tcd_pkg::*;
#(
  parameter tbl_e TBL = TBL_LADDER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             gate_off_i,
  output logic             pulse_o,
  output logic             divclk_o,
  output logic             err_o
);
  ratio_t ratio_q, cnt_q, new_ratio;
  logic   code_ok, run_q, pulse_q, clk_q, err_q;
  logic   at_end, boundary, load_ratio, half_on;

  tcd_decode #(.TBL(TBL)) u_dec (
    .sel_i   (sel_i),
    .ratio_o (new_ratio),
    .valid_o (code_ok)
  );

  // Named events used by logic and assertions.
  assign at_end     = run_q && (cnt_q == ratio_q - ratio_t'(1));
  assign boundary   = at_end || !run_q;
  assign load_ratio = code_ok && boundary;
  assign half_on    = run_q && (cnt_q < (ratio_q >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= boot_ratio(TBL);
      cnt_q   <= '0;
      run_q   <= 1'b1;
      pulse_q <= 1'b0;
      clk_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= at_end;
      clk_q   <= half_on;
      err_q   <= err_q | !code_ok;
      if (load_ratio) ratio_q <= new_ratio;
      if (boundary) begin
        cnt_q <= '0;
        run_q <= !gate_off_i;
      end else begin
        cnt_q <= cnt_q + ratio_t'(1);
      end
    end
  end

  assign pulse_o  = pulse_q;
  assign divclk_o = clk_q;
  assign err_o    = err_q;

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_ratio_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $past(boundary));
  assert_reserved_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |=> $stable(ratio_q));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!pulse_q && !clk_q));
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == '0));
endmodule

// File: rtl/tbl_clkdiv_top.sv
module tbl_clkdiv_top
  import tcd_pkg::*;
#(
  parameter int NUM_SHARED = 3,
  parameter int GATE_BIT   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SHARED*SEL_W-1:0] share_ctl,
  input  logic [GATE_BIT:0]           gate_ctl,
  output logic [NUM_SHARED:0]         pulse_o,
  output logic [NUM_SHARED:0]         divclk_o,
  output logic [NUM_SHARED:0]         err_o
);
  localparam int GATED_CH = NUM_SHARED;

  logic unused_gate_bits;
  assign unused_gate_bits = ^gate_ctl[GATE_BIT-1:SEL_W];

  for (genvar g = 0; g < NUM_SHARED; g++) begin : g_shared
    localparam tbl_e TBL_G = (g == 0) ? TBL_LADDER : TBL_SPARSE;
    localparam int   LSB_G = (NUM_SHARED - 1 - g) * SEL_W;
    tcd_channel #(.TBL(TBL_G)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (share_ctl[LSB_G +: SEL_W]),
      .gate_off_i (1'b0),
      .pulse_o    (pulse_o[g]),
      .divclk_o   (divclk_o[g]),
      .err_o      (err_o[g])
    );
  end

  tcd_channel #(.TBL(TBL_NOZERO)) u_gated (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (gate_ctl[SEL_W-1:0]),
    .gate_off_i (gate_ctl[GATE_BIT]),
    .pulse_o    (pulse_o[GATED_CH]),
    .divclk_o   (divclk_o[GATED_CH]),
    .err_o      (err_o[GATED_CH])
  );
endmodule

// File: tb/tbl_clkdiv_top_tb.sv
module tbl_clkdiv_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] share_ctl = 12'h044;
  logic [8:0]  gate_ctl = 9'h001;
  logic [3:0]  pulse_o, divclk_o, err_o;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R10";

  int tA[16] = '{2,3,4,6,8,12,16,18,24,0,36,48,0,0,0,0};
  int tB[16] = '{0,0,0,0,8,12,16,18,24,0,36,48,10,0,0,0};
  int tC[16] = '{0,3,4,6,8,12,16,18,24,0,36,48,0,0,0,0};
  int boot[4] = '{2,8,8,3};
  int m_cnt[4], m_ratio[4], m_run[4], m_err[4], m_pulse[4], m_clk[4];

  tbl_clkdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .share_ctl(share_ctl), .gate_ctl(gate_ctl),
    .pulse_o(pulse_o), .divclk_o(divclk_o), .err_o(err_o));

  always #5 clk = ~clk;

  function automatic int field(int ch);
    if (ch < 3) return int'(share_ctl[(2-ch)*4 +: 4]);
    return int'(gate_ctl[3:0]);
  endfunction

  function automatic int lut(int ch, int code);
    if (ch == 0) return tA[code];
    if (ch == 3) return tC[code];
    return tB[code];
  endfunction

  // Behavioural reference model, one step per rising edge.
  always @(posedge clk) begin
    cyc++;
    for (int ch = 0; ch < 4; ch++) begin
      if (!rst_n) begin
        m_cnt[ch] = 0; m_ratio[ch] = boot[ch]; m_run[ch] = 1;
        m_err[ch] = 0; m_pulse[ch] = 0; m_clk[ch] = 0;
      end else begin
        int r;
        int off;
        r = lut(ch, field(ch));
        off = (ch == 3) ? int'(gate_ctl[8]) : 0;
        m_clk[ch] = (m_run[ch] != 0 && m_cnt[ch] < m_ratio[ch] / 2) ? 1 : 0;
        if (m_run[ch] != 0 && m_cnt[ch] == m_ratio[ch] - 1) begin
          m_pulse[ch] = 1; m_cnt[ch] = 0;
          if (r != 0) m_ratio[ch] = r;
          m_run[ch] = off ? 0 : 1;
        end else if (m_run[ch] == 0) begin
          m_pulse[ch] = 0; m_cnt[ch] = 0;
          if (r != 0) m_ratio[ch] = r;
          m_run[ch] = off ? 0 : 1;
        end else begin
          m_pulse[ch] = 0; m_cnt[ch]++;
        end
        if (r == 0) m_err[ch] = 1;
      end
    end
    if (cyc == 150000) begin
      bad++;
      $display("FAIL watchdog (%s) act=%0d exp=done", cur_req, cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int ch = 0; ch < 4; ch++) begin
        check(cur_req, $sformatf("ch%0d pulse", ch), int'(pulse_o[ch]), m_pulse[ch]);
        check(cur_req, $sformatf("ch%0d divclk", ch), int'(divclk_o[ch]), m_clk[ch]);
        check(cur_req, $sformatf("ch%0d err", ch), int'(err_o[ch]), m_err[ch]);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic set_code(int ch, int code);
    if (ch < 3) share_ctl[(2-ch)*4 +: 4] = 4'(code);
    else gate_ctl[3:0] = 4'(code);
  endtask

  task automatic sweep(int ch, string req);
    cur_req = req;
    do_reset();
    for (int c = 0; c < 16; c++) begin
      if (lut(ch, c) != 0) begin set_code(ch, c); wait_cyc(110); end
    end
    check(req, "err after valid codes (R6)", int'(err_o[ch]), 0);
    for (int c = 0; c < 16; c++) begin
      if (lut(ch, c) == 0) begin set_code(ch, c); wait_cyc(30); end
    end
    check(req, "err after reserved codes (R6)", int'(err_o[ch]), 1);
    set_code(ch, (ch == 0) ? 1 : 4);
    wait_cyc(60);
    check(req, "err stays sticky (R6)", int'(err_o[ch]), 1);
  endtask

  initial begin
    int seen;
    wait_cyc(4);
    rst_n = 1'b1;
    // R10: outputs clear right after reset, before any edge
    check("R10", "pulse after reset", int'(pulse_o), 0);
    check("R10", "divclk after reset", int'(divclk_o), 0);
    check("R10", "err after reset", int'(err_o), 0);
    cmp_on = 1'b1;
    wait_cyc(60);

    sweep(0, "R1/R4/R9");
    sweep(1, "R2/R4/R9");
    sweep(2, "R2/R4/R9");
    sweep(3, "R3/R4/R9");

    // R5: rapid code changes within periods
    cur_req = "R5";
    do_reset();
    for (int i = 0; i < 40; i++) begin
      set_code(1, 4 + (i % 9));
      set_code(0, i % 12);
      wait_cyc(7);
    end
    wait_cyc(60);

    // R7/R8: gating of channel 3, upper bits ignored (R3)
    cur_req = "R7";
    do_reset();
    gate_ctl = 9'h0A2;
    wait_cyc(13);
    gate_ctl[8] = 1'b1;
    wait_cyc(40);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pulse_o[3] || divclk_o[3]) seen++;
    end
    check("R7", "ch3 activity while stopped", seen, 0);
    gate_ctl[3:0] = 4'd10;
    gate_ctl[7:4] = 4'h5;
    cur_req = "R8";
    gate_ctl[8] = 1'b0;
    wait_cyc(100);
    gate_ctl[3:0] = 4'd1;
    wait_cyc(40);
    gate_ctl[8] = 1'b1;
    wait_cyc(1);
    gate_ctl[8] = 1'b0;
    wait_cyc(30);
    for (int i = 0; i < 6; i++) begin
      gate_ctl[8] = ~gate_ctl[8];
      wait_cyc(5 + i);
    end
    gate_ctl[8] = 1'b0;
    wait_cyc(60);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule